// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight-bit status word of a small 8-bit CPU core. Five bits record facts about the last result: carry, zero, overflow and negative, plus a break marker that is only meaningful in a stacked copy. The three control bits are interrupt mask, decimal mode and a spare bit. The ALU and the data-transfer path send update strobes with their result values. The instruction decoder sends a 3-bit single-flag command code. The interrupt sequencer signals acceptance of an interrupt, and the pull-status path loads a byte read back from the stack.

When an interrupt is accepted, the block captures the byte to be pushed on the stack. That byte is the live word as it stood before entry, with the break bit set only when a software break caused the entry. In the same cycle the live interrupt-mask bit is forced high. A pull load replaces the whole live word in one cycle and wins over every other update that arrives in the same cycle. The live break bit always reads 0 and the spare bit always reads its reset value, whatever data is pulled.

Bit positions: carry 0, zero 1, interrupt mask 2, decimal 3, break 4, spare 5, overflow 6, negative 7.

Top module: `psw_reg`

## Requirements
- R1: In the cycle after synchronous reset, `flags` is 0x24: mask bit 2 = 1, spare bit 5 = 1, every other bit 0. `push_image` is 0x20.
- R2: Carry (bit 0) takes `alu_c` on the edge where `alu_c_upd` is high. A same-cycle set-carry or clear-carry command wins over the strobe.
- R3: On the edge where `res_upd` is high, zero (bit 1) becomes 1 exactly when `res_data` is all zeros, and negative (bit 7) takes the most significant bit of `res_data`.
- R4: Overflow (bit 6) takes `alu_v` on the edge where `alu_v_upd` is high. A same-cycle clear-overflow command wins over the strobe.
- R5: Set-mask and clear-mask commands drive bit 2. When `irq_take` is high, bit 2 is 1 after that edge, even if a clear-mask command arrives in the same cycle.
- R6: Set-decimal and clear-decimal commands drive bit 3. The bit keeps its value through all ALU and result strobes.
- R7: When `pull_load` is high, `flags` becomes `pull_data` after the edge, with bit 4 forced to 0 and bit 5 forced to 1. All same-cycle strobes, commands and interrupt entry are ignored.
- R8: On the edge where `irq_take` is high, `push_image` becomes the pre-entry `flags` with bit 4 = `irq_is_brk` and bit 5 = 1. It holds that value until the next `irq_take`.
- R9: `cmd_op` codes are 0 none, 1 set carry, 2 clear carry, 3 set mask, 4 clear mask, 5 set decimal, 6 clear decimal, 7 clear overflow. A code changes only its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_upd | input | 1 | Load zero and negative from `res_data` |
| res_data | input | DW | Arithmetic or transfer result |
| alu_c_upd | input | 1 | Load carry from `alu_c` |
| alu_c | input | 1 | ALU carry or borrow |
| alu_v_upd | input | 1 | Load overflow from `alu_v` |
| alu_v | input | 1 | ALU overflow |
| cmd_op | input | 3 | Single-flag command code (R9) |
| irq_take | input | 1 | Interrupt accepted this cycle |
| irq_is_brk | input | 1 | Entry caused by software break |
| pull_load | input | 1 | Load the status word from the stack |
| pull_data | input | 8 | Status byte read from the stack |
| flags | output | 8 | Live status word |
| push_image | output | 8 | Status byte to be pushed at interrupt entry |

## Verification
Every live bit is a register that feeds `flags` directly. A wrong next-state value, a priority error or a lost update therefore appears at the port one edge after the stimulus, and it stays there until something rewrites that bit. A fault in the decimal or mask bit can persist for many cycles, because only commands change those bits. The bench compares every bit after every cycle, so the first bad edge is the one reported. A bad stacked image shows on `push_image` in the cycle after `irq_take`.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W = 8;
  localparam int B_C = 0;
  localparam int B_Z = 1;
  localparam int B_I = 2;
  localparam int B_D = 3;
  localparam int B_B = 4;
  localparam int B_S = 5;
  localparam int B_V = 6;
  localparam int B_N = 7;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_SETC = 3'd1,
    OP_CLRC = 3'd2,
    OP_SETI = 3'd3,
    OP_CLRI = 3'd4,
    OP_SETD = 3'd5,
    OP_CLRD = 3'd6,
    OP_CLRV = 3'd7
  } psw_op_e;

  function automatic logic [PSW_W-1:0] reset_flags(logic spare);
    logic [PSW_W-1:0] r;
    r = '0;
    r[B_I] = 1'b1;
    r[B_S] = spare;
    return r;
  endfunction
endpackage

// File: rtl/psw_cmd_dec.sv
module psw_cmd_dec
  import psw_pkg::*;
(
  input  psw_op_e          op,
  output logic [PSW_W-1:0] set_v,
  output logic [PSW_W-1:0] clr_v
);
  always_comb begin
    set_v = '0;
    clr_v = '0;
    case (op)
      OP_SETC: set_v[B_C] = 1'b1;
      OP_CLRC: clr_v[B_C] = 1'b1;
      OP_SETI: set_v[B_I] = 1'b1;
      OP_CLRI: clr_v[B_I] = 1'b1;
      OP_SETD: set_v[B_D] = 1'b1;
      OP_CLRD: clr_v[B_D] = 1'b1;
      OP_CLRV: clr_v[B_V] = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/psw_bit.sv
module psw_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pull,
  input  logic pull_val,
  input  logic force_one,
  input  logic set_one,
  input  logic clr_zero,
  input  logic upd,
  input  logic upd_val,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)            q <= RST_VAL;
    else if (pull)      q <= pull_val;
    else if (force_one) q <= 1'b1;
    else if (set_one)   q <= 1'b1;
    else if (clr_zero)  q <= 1'b0;
    else if (upd)       q <= upd_val;
  end
endmodule

// File: rtl/psw_push_img.sv
module psw_push_img
  import psw_pkg::*;
#(
  parameter logic SPARE_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             brk,
  input  logic [PSW_W-1:0] live,
  output logic [PSW_W-1:0] img
);
  logic [PSW_W-1:0] img_n;
  logic [PSW_W-1:0] img_rst;

  always_comb begin
    img_n      = live;
    img_n[B_B] = brk;
    img_n[B_S] = SPARE_VAL;
    img_rst      = '0;
    img_rst[B_S] = SPARE_VAL;
  end

  always_ff @(posedge clk) begin
    if (rst)       img <= img_rst;
    else if (take) img <= img_n;
  end

  a_r8_brk_source: assert property (@(posedge clk) disable iff (rst)
    take |=> (img[B_B] == $past(brk)) && (img[B_S] == SPARE_VAL));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!take && !$past(rst)) |=> $stable(img));
endmodule

// File: rtl/psw_reg.sv
module psw_reg
  import psw_pkg::*;
#(
  parameter int   DW        = 8,
  parameter logic SPARE_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_upd,
  input  logic [DW-1:0]    res_data,
  input  logic             alu_c_upd,
  input  logic             alu_c,
  input  logic             alu_v_upd,
  input  logic             alu_v,
  input  logic [2:0]       cmd_op,
  input  logic             irq_take,
  input  logic             irq_is_brk,
  input  logic             pull_load,
  input  logic [PSW_W-1:0] pull_data,
  output logic [PSW_W-1:0] flags,
  output logic [PSW_W-1:0] push_image
);
  localparam logic [PSW_W-1:0] RST_FLAGS = reset_flags(SPARE_VAL);
  localparam int               MSB       = DW - 1;

  psw_op_e          op_e;
  logic [PSW_W-1:0] set_v, clr_v, upd_en, upd_val, pull_val, force_v;

  assign op_e = psw_op_e'(cmd_op);

  psw_cmd_dec u_dec (
    .op    (op_e),
    .set_v (set_v),
    .clr_v (clr_v)
  );

  always_comb begin
    upd_en   = '0;
    upd_val  = '0;
    force_v  = '0;
    pull_val = pull_data;
    upd_en[B_C]  = alu_c_upd;
    upd_val[B_C] = alu_c;
    upd_en[B_V]  = alu_v_upd;
    upd_val[B_V] = alu_v;
    upd_en[B_Z]  = res_upd;
    upd_val[B_Z] = ~|res_data;
    upd_en[B_N]  = res_upd;
    upd_val[B_N] = res_data[MSB];
    force_v[B_I] = irq_take;
    pull_val[B_B] = 1'b0;
    pull_val[B_S] = SPARE_VAL;
  end

  for (genvar g = 0; g < PSW_W; g++) begin : g_bit
    psw_bit #(.RST_VAL(RST_FLAGS[g])) u_bit (
      .clk       (clk),
      .rst       (rst),
      .pull      (pull_load),
      .pull_val  (pull_val[g]),
      .force_one (force_v[g]),
      .set_one   (set_v[g]),
      .clr_zero  (clr_v[g]),
      .upd       (upd_en[g]),
      .upd_val   (upd_val[g]),
      .q         (flags[g])
    );
  end

  psw_push_img #(.SPARE_VAL(SPARE_VAL)) u_push (
    .clk  (clk),
    .rst  (rst),
    .take (irq_take),
    .brk  (irq_is_brk),
    .live (flags),
    .img  (push_image)
  );

  a_r1_reset_value: assert property (@(posedge clk)
    $past(rst) |-> flags == RST_FLAGS);
  a_r3_zero_result: assert property (@(posedge clk) disable iff (rst)
    (res_upd && !pull_load) |=> flags[B_Z] == ($past(res_data) == '0));
  a_r5_irq_masks: assert property (@(posedge clk) disable iff (rst)
    (irq_take && !pull_load) |=> flags[B_I]);
  a_r7_pull_load: assert property (@(posedge clk) disable iff (rst)
    pull_load |=> (flags[7:6] == $past(pull_data[7:6])) &&
                  (flags[3:0] == $past(pull_data[3:0])) &&
                  (flags[B_B] == 1'b0) && (flags[B_S] == SPARE_VAL));
  a_r9_single_target: assert property (@(posedge clk) disable iff (rst)
    $countones({set_v, clr_v}) <= 1);
endmodule

// File: tb/psw_reg_tb_top.sv
module psw_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       res_upd = 0, alu_c_upd = 0, alu_c = 0, alu_v_upd = 0, alu_v = 0;
  logic [7:0] res_data = 0, pull_data = 0;
  logic [2:0] cmd_op = 0;
  logic       irq_take = 0, irq_is_brk = 0, pull_load = 0;
  logic [7:0] flags, push_image;
  logic [7:0] m_flags, m_img;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  psw_reg dut_i (
    .clk(clk), .rst(rst), .res_upd(res_upd), .res_data(res_data),
    .alu_c_upd(alu_c_upd), .alu_c(alu_c), .alu_v_upd(alu_v_upd), .alu_v(alu_v),
    .cmd_op(cmd_op), .irq_take(irq_take), .irq_is_brk(irq_is_brk),
    .pull_load(pull_load), .pull_data(pull_data),
    .flags(flags), .push_image(push_image)
  );

  function automatic logic [7:0] nxt(logic [7:0] f);
    logic [7:0] n;
    if (pull_load) return {pull_data[7:6], 2'b10, pull_data[3:0]};
    n = f;
    if (res_upd) begin n[1] = (res_data == 8'h00); n[7] = res_data[7]; end
    if (alu_v_upd) n[6] = alu_v;
    if (alu_c_upd) n[0] = alu_c;
    case (cmd_op)
      3'd1: n[0] = 1'b1;  3'd2: n[0] = 1'b0;
      3'd3: n[2] = 1'b1;  3'd4: n[2] = 1'b0;
      3'd5: n[3] = 1'b1;  3'd6: n[3] = 1'b0;
      3'd7: n[6] = 1'b0;  default: ;
    endcase
    if (irq_take) n[2] = 1'b1;
    return n;
  endfunction

  function automatic string req_of(int b);
    case (b)
      0: return "R2";  1: return "R3";  2: return "R5";  3: return "R6";
      6: return "R4";  7: return "R3";  default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    res_upd = 0; alu_c_upd = 0; alu_v_upd = 0; cmd_op = 0;
    irq_take = 0; irq_is_brk = 0; pull_load = 0;
  endtask

  // inputs are already set; advance one edge and compare against the model
  task automatic step();
    logic [7:0] nf, ni;
    nf = nxt(m_flags);
    ni = m_img;
    if (irq_take && !pull_load) ni = {m_flags[7:6], 1'b1, irq_is_brk, m_flags[3:0]};
    else if (irq_take) ni = {m_flags[7:6], 1'b1, irq_is_brk, m_flags[3:0]};
    m_flags = nf; m_img = ni;
    @(negedge clk);
    for (int b = 0; b < 8; b++) chk(req_of(b), {7'd0, flags[b]}, {7'd0, m_flags[b]});
    chk("R8", push_image, m_img);
    idle();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1", flags, 8'h24);
    chk("R1", push_image, 8'h20);
    m_flags = 8'h24; m_img = 8'h20;

    // R9 / R2: set carry wins over ALU carry 0
    cmd_op = 3'd1; alu_c_upd = 1; alu_c = 0; step();
    chk("R2", {7'd0, flags[0]}, 8'd1);
    // R4: clear-overflow wins over ALU overflow 1
    cmd_op = 3'd7; alu_v_upd = 1; alu_v = 1; step();
    chk("R4", {7'd0, flags[6]}, 8'd0);
    // R3: zero result then negative result
    res_upd = 1; res_data = 8'h00; step();
    chk("R3", flags & 8'h82, 8'h02);
    res_upd = 1; res_data = 8'h80; step();
    chk("R3", flags & 8'h82, 8'h80);
    // R6: decimal set survives strobes
    cmd_op = 3'd5; step();
    res_upd = 1; res_data = 8'h01; alu_c_upd = 1; alu_c = 1; alu_v_upd = 1; alu_v = 1; step();
    chk("R6", {7'd0, flags[3]}, 8'd1);
    // R5: clear mask, then irq with clear-mask in the same cycle
    cmd_op = 3'd4; step();
    chk("R5", {7'd0, flags[2]}, 8'd0);
    irq_take = 1; irq_is_brk = 1; cmd_op = 3'd4; step();
    chk("R5", {7'd0, flags[2]}, 8'd1);
    chk("R8", push_image, 8'h79);
    irq_take = 1; irq_is_brk = 0; step();
    chk("R8", push_image, 8'h6D);
    // R7: pull wins over everything
    pull_load = 1; pull_data = 8'hFF; irq_take = 1; cmd_op = 3'd2; res_upd = 1; res_data = 8'h00; step();
    chk("R7", flags, 8'hEF);
    pull_load = 1; pull_data = 8'h00; cmd_op = 3'd3; step();
    chk("R7", flags, 8'h20);

    for (int i = 0; i < 3000; i++) begin
      res_upd   = ($urandom % 3) == 0;
      res_data  = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
      alu_c_upd = $urandom % 2; alu_c = $urandom % 2;
      alu_v_upd = $urandom % 2; alu_v = $urandom % 2;
      cmd_op    = ($urandom % 2) ? 3'($urandom) : 3'd0;
      irq_take  = ($urandom % 12) == 0; irq_is_brk = $urandom % 2;
      pull_load = ($urandom % 16) == 0; pull_data = 8'($urandom);
      step();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule